// File: doc/BRIEF.md
# Power-Fail Chip-Enable Conditioner

This block sits between a processor's active-low memory enable and up to four battery-backed static memories. A two-bit select picks which memory receives the enable, and the block drives one active-low conditioned enable per memory. While the supply is good, the enable passes straight through the decode. When a digital power-fail flag rises, the block write-protects every memory by forcing all conditioned enables high. An access that has already started may run to its end, but only for a bounded number of clocks.

The flag stands in for an external supply comparator and may change at any time, so it is synchronized before use. After the flag clears, every memory stays deselected for a chip-enable recovery interval. An active-low system reset output follows the same fault, with its own release interval. Every time value is a clock-count parameter.

Top module: `pfce_conditioner`

## Requirements
- R1: While the power gate is open and `ce_n_i` is high, all bits of `ce_n_o` are high.
- R2: While the power gate is open and `ce_n_i` is low, exactly one bit of `ce_n_o` is low: bit index equals `sel_i` read as an unsigned number (0 gives bit 0, 1 gives bit 1, 2 gives bit 2, 3 gives bit 3). The select is used combinationally, so no setup time before the enable's falling edge is needed.
- R3: `pwr_fail_i` passes through a two-flop synchronizer that resets to the failed value. The block first acts on a new flag value at the third rising edge that samples it.
- R4: When the synchronized flag is seen high with `ce_n_i` high, all outputs are forced high from the next edge, whatever `ce_n_i` does, until recovery completes.
- R5: When the synchronized flag is seen high with `ce_n_i` low, the outputs keep following the decode until `ce_n_i` rises. From the edge that sees `ce_n_i` high, all outputs are forced high.
- R6: If that access is still running WPT_CYCLES edges after the drain began, all outputs are forced high unconditionally from that edge.
- R7: After the synchronized flag is seen low in the protected state, all outputs stay high for CE_REC_CYCLES clocks, then follow R1/R2 again.
- R8: If the synchronized flag is seen high during the recovery hold, the block returns to the protected state, and the full recovery count restarts on the next deassertion.
- R9: `sys_rst_n_o` goes low at the edge after the synchronized flag is seen high, which is within the write-protect time.
- R10: `sys_rst_n_o` rises RST_REC_CYCLES edges after the synchronized flag is first seen low. A reassertion before then restarts that count.
- R11: Under `rst_ni` low the block is protected with `sys_rst_n_o` low and all outputs high. After release, it runs the full recovery of R7 and R10 once the flag reads valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_fail_i | input | 1 | Power-fail flag, high means supply out of tolerance, asynchronous |
| ce_n_i | input | 1 | Active-low chip enable from the processor |
| sel_i | input | SEL_W (2) | Memory select |
| ce_n_o | output | 2**SEL_W (4) | Conditioned active-low enables, one per memory |
| sys_rst_n_o | output | 1 | Active-low system reset |

## Verification
The hardest situations to reach are the bounded drain and a fault during recovery. The drain needs the flag to arrive while the enable is already low. The bench holds an access open, raises the flag, and then either ends the access early or keeps it low past the write-protect count. For the refault case, the bench drops the flag, waits part of the recovery hold, raises it again briefly, and then releases it. A behavioural reference model tracks each of these paths and compares every output on every clock, so the restarted recovery and reset counts are checked to the exact cycle.

// File: rtl/pfce_pkg.sv
package pfce_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_HOLD    = 2'd2,
        ST_RECOVER = 2'd3
    } pfce_state_e;

    function automatic int unsigned pfce_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pfce_sync.sv
module pfce_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    // reset to the failed value so the block starts protected
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfce_fsm.sv
module pfce_fsm
    import pfce_pkg::*;
#(
    parameter int unsigned WPT_CYCLES    = 16,
    parameter int unsigned CE_REC_CYCLES = 100,
    parameter int unsigned CNT_W         = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fail_i,
    input  logic              ce_n_i,
    output pfce_state_e       state_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              gate_o
);
    localparam logic [CNT_W-1:0] WPT_LAST = CNT_W'(WPT_CYCLES - 1);
    localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(CE_REC_CYCLES - 1);

    typedef struct packed {
        pfce_state_e      st;
        logic [CNT_W-1:0] cnt;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_RUN: begin
                if (fail_i) begin
                    r_d.cnt = '0;
                    r_d.st  = ce_n_i ? ST_HOLD : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (ce_n_i || (r_q.cnt == WPT_LAST)) begin
                    r_d.st  = ST_HOLD;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (!fail_i) begin
                    r_d.st  = ST_RECOVER;
                    r_d.cnt = '0;
                end
            end
            ST_RECOVER: begin
                if (fail_i) begin
                    r_d.st  = ST_HOLD;
                    r_d.cnt = '0;
                end else if (r_q.cnt == REC_LAST) begin
                    r_d.st  = ST_RUN;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            default: begin
                r_d.st  = ST_HOLD;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st  <= ST_HOLD;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;
    assign cnt_o   = r_q.cnt;
    assign gate_o  = (r_q.st == ST_RUN) || (r_q.st == ST_DRAIN);
endmodule

// File: rtl/pfce_rst_timer.sv
module pfce_rst_timer #(
    parameter int unsigned RST_REC_CYCLES = 120
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fail_i,
    output logic sys_rst_n_o
);
    localparam int unsigned TW = $clog2(RST_REC_CYCLES + 1);
    localparam logic [TW-1:0] HOLD_LAST = TW'(RST_REC_CYCLES - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          done;
    } tmr_regs_t;

    tmr_regs_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (fail_i) begin
            t_d.cnt  = '0;
            t_d.done = 1'b0;
        end else if (!t_q.done) begin
            if (t_q.cnt == HOLD_LAST) t_d.done = 1'b1;
            else                      t_d.cnt  = t_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            t_q.cnt  <= '0;
            t_q.done <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign sys_rst_n_o = t_q.done;
endmodule

// File: rtl/pfce_decode.sv
module pfce_decode #(
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned NUM_OUT = 1 << SEL_W
) (
    input  logic               gate_i,
    input  logic               ce_n_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic [NUM_OUT-1:0] ce_n_o
);
    logic active;
    assign active = gate_i & ~ce_n_i;

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
            assign ce_n_o[i] = ~(active & (sel_i == SEL_W'(i)));
        end
    endgenerate
endmodule

// File: rtl/pfce_conditioner.sv
module pfce_conditioner
    import pfce_pkg::*;
#(
    parameter int unsigned SEL_W          = 2,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned WPT_CYCLES     = 16,
    parameter int unsigned CE_REC_CYCLES  = 100,
    parameter int unsigned RST_REC_CYCLES = 120
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     pwr_fail_i,
    input  logic                     ce_n_i,
    input  logic [SEL_W-1:0]         sel_i,
    output logic [(1<<SEL_W)-1:0]    ce_n_o,
    output logic                     sys_rst_n_o
);
    localparam int unsigned NUM_OUT = 1 << SEL_W;
    localparam int unsigned CNT_W   = $clog2(pfce_max(WPT_CYCLES, CE_REC_CYCLES) + 1);

    logic             fail_s;
    logic             gate;
    pfce_state_e      fsm_state;
    logic [CNT_W-1:0] fsm_cnt;

    pfce_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pwr_fail_i),
        .sync_o  (fail_s)
    );

    pfce_fsm #(
        .WPT_CYCLES    (WPT_CYCLES),
        .CE_REC_CYCLES (CE_REC_CYCLES),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fail_i  (fail_s),
        .ce_n_i  (ce_n_i),
        .state_o (fsm_state),
        .cnt_o   (fsm_cnt),
        .gate_o  (gate)
    );

    pfce_rst_timer #(.RST_REC_CYCLES(RST_REC_CYCLES)) u_rst (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fail_i      (fail_s),
        .sys_rst_n_o (sys_rst_n_o)
    );

    pfce_decode #(.SEL_W(SEL_W), .NUM_OUT(NUM_OUT)) u_dec (
        .gate_i (gate),
        .ce_n_i (ce_n_i),
        .sel_i  (sel_i),
        .ce_n_o (ce_n_o)
    );
endmodule

// File: rtl/pfce_checker.sv
module pfce_checker
    import pfce_pkg::*;
#(
    parameter int unsigned NUM_OUT    = 4,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned WPT_CYCLES = 16
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               ce_n_i,
    input logic [NUM_OUT-1:0] ce_n_o,
    input logic               sys_rst_n_o,
    input logic               fail_s,
    input pfce_state_e        fsm_state,
    input logic [CNT_W-1:0]   fsm_cnt
);
    // R1: idle enable never selects a memory
    a_r1_idle_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_n_i |-> (ce_n_o == '1));

    // R2: at most one memory selected
    a_r2_single_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(~ce_n_o) <= 1);

    // R4: protected state keeps every memory deselected
    a_r4_hold_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_state == ST_HOLD) |-> (ce_n_o == '1));

    // R5: a finished access ends the drain
    a_r5_drain_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_state == ST_DRAIN && ce_n_i) |=> (fsm_state == ST_HOLD));

    // R6: drain never outlives the write-protect count
    a_r6_drain_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_state == ST_DRAIN) |-> (fsm_cnt < WPT_CYCLES));

    // R7: recovery hold keeps every memory deselected
    a_r7_recover_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_state == ST_RECOVER) |-> (ce_n_o == '1));

    // R8: refault during recovery returns to protection
    a_r8_refail: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_state == ST_RECOVER && fail_s) |=> (fsm_state == ST_HOLD));

    // R9: fault while running drops the system reset
    a_r9_rst_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_state == ST_RUN && fail_s) |=> !sys_rst_n_o);

    // R10: reset only releases with the flag valid
    a_r10_release_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sys_rst_n_o) |-> $past(!fail_s));
endmodule

bind pfce_conditioner pfce_checker #(
    .NUM_OUT    (NUM_OUT),
    .CNT_W      (CNT_W),
    .WPT_CYCLES (WPT_CYCLES)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_n_i      (ce_n_i),
    .ce_n_o      (ce_n_o),
    .sys_rst_n_o (sys_rst_n_o),
    .fail_s      (fail_s),
    .fsm_state   (fsm_state),
    .fsm_cnt     (fsm_cnt)
);

// File: tb/sim_pfce_conditioner.sv
`timescale 1ns/1ps
module sim_pfce_conditioner;
    localparam int WPT = 5;
    localparam int CER = 12;
    localparam int RRC = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pf = 1'b0;
    logic       ce_n = 1'b1;
    logic [1:0] sel = 2'd0;
    logic [3:0] ce_out;
    logic       sys_rst_n;

    int checks = 0;
    int errors = 0;
    string cur_req = "R11";

    always #10 clk = ~clk;

    pfce_conditioner #(
        .SEL_W(2), .SYNC_STAGES(2), .WPT_CYCLES(WPT),
        .CE_REC_CYCLES(CER), .RST_REC_CYCLES(RRC)
    ) u0 (
        .clk_i(clk), .rst_ni(rst_n), .pwr_fail_i(pf), .ce_n_i(ce_n),
        .sel_i(sel), .ce_n_o(ce_out), .sys_rst_n_o(sys_rst_n)
    );

    // behavioural reference: 0 run, 1 draining, 2 protected, 3 recovering
    bit m_s1 = 1, m_s2 = 1;
    int m_mode = 2;
    int m_cnt = 0;
    int m_rcnt = 0;
    bit m_rdone = 0;
    bit started = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_mode = 2; m_cnt = 0; m_rcnt = 0; m_rdone = 0;
        end else begin
            started = 1;
            if (m_mode == 0) begin
                if (m_s2) begin m_mode = ce_n ? 2 : 1; m_cnt = 0; end
            end else if (m_mode == 1) begin
                if (ce_n || m_cnt == WPT - 1) begin m_mode = 2; m_cnt = 0; end
                else m_cnt++;
            end else if (m_mode == 2) begin
                if (!m_s2) begin m_mode = 3; m_cnt = 0; end
            end else begin
                if (m_s2) begin m_mode = 2; m_cnt = 0; end
                else if (m_cnt == CER - 1) begin m_mode = 0; m_cnt = 0; end
                else m_cnt++;
            end
            if (m_s2) begin m_rcnt = 0; m_rdone = 0; end
            else if (!m_rdone) begin
                if (m_rcnt == RRC - 1) m_rdone = 1;
                else m_rcnt++;
            end
            m_s2 = m_s1;
            m_s1 = pf;
        end
    end

    function automatic logic [3:0] model_out();
        if ((m_mode == 0 || m_mode == 1) && !ce_n) return ~(4'b0001 << sel);
        return 4'hF;
    endfunction

    task automatic check4(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s ce_n_o actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s sys_rst_n_o actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        #5;
        if (started) begin
            check4(cur_req, ce_out, model_out());
            check1(cur_req, sys_rst_n, m_rdone);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(3);
        cur_req = "R11";
        #5;
        check4("R11", ce_out, 4'hF);
        check1("R11", sys_rst_n, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        ce_n = 1'b0; sel = 2'd1;
        step(4);
        #5 check4("R7", ce_out, 4'hF);
        step(RRC + 4);

        cur_req = "R2";
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            ce_n = 1'b0; sel = 2'(s);
            #5 check4("R2", ce_out, ~(4'b0001 << s));
        end
        cur_req = "R1";
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            ce_n = 1'b1; sel = 2'(s);
            #5 check4("R1", ce_out, 4'hF);
        end

        // R3 latency and R9 reset assertion, no access active (R4)
        cur_req = "R3";
        @(negedge clk);
        pf = 1'b1;
        @(negedge clk); #5 check1("R3", sys_rst_n, 1'b1);
        @(negedge clk); #5 check1("R3", sys_rst_n, 1'b1);
        @(negedge clk); #5 check1("R9", sys_rst_n, 1'b0);
        cur_req = "R4";
        @(negedge clk);
        ce_n = 1'b0; sel = 2'd2;
        #5 check4("R4", ce_out, 4'hF);
        step(6);

        cur_req = "R10";
        @(negedge clk);
        pf = 1'b0; ce_n = 1'b0; sel = 2'd1;
        step(RRC + 6);
        #5 check4("R7", ce_out, 4'b1101);

        // R5: access in progress ends before the timeout
        cur_req = "R5";
        @(negedge clk);
        ce_n = 1'b0; sel = 2'd3; pf = 1'b1;
        step(3);
        #5 check4("R5", ce_out, 4'b0111);
        @(negedge clk);
        ce_n = 1'b1;
        step(2);
        ce_n = 1'b0;
        #5 check4("R5", ce_out, 4'hF);
        @(negedge clk);
        pf = 1'b0;
        step(RRC + 6);

        // R6: access held past the write-protect count
        cur_req = "R6";
        @(negedge clk);
        ce_n = 1'b0; sel = 2'd0; pf = 1'b1;
        step(WPT + 6);
        #5 check4("R6", ce_out, 4'hF);
        @(negedge clk);
        pf = 1'b0;

        // R8: refault in the middle of the recovery hold
        cur_req = "R8";
        step(6);
        pf = 1'b1;
        step(3);
        pf = 1'b0;
        step(CER / 2 + 3);
        #5 check4("R8", ce_out, 4'hF);
        check1("R10", sys_rst_n, 1'b0);
        step(RRC + 4);
        #5 check4("R8", ce_out, 4'b1110);
        check1("R10", sys_rst_n, 1'b1);

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule